// File: doc/BRIEF.md
# UART Status and Interrupt Unit

This block sits between the serial engines of a UART and the CPU bus. It gathers the condition flags of both directions into one 8-bit status byte. It also drives a single active-low interrupt request. The sources of a request are a received character, a transmitter that can take a new character, a transmitter that has gone fully idle, a falling edge on a peripheral-status line, and a rising edge on clear-to-send while the transmitter is idle. Each source is latched as its own pending cause. The cause is set by its own event and cleared by the CPU access that the bus logic reports as a one-cycle strobe. Those accesses are a data read, a status read, or a character write.

The transmitter flags arrive as synchronous levels. A small three-state tracker (`TX_BUSY`, `TX_RELOAD`, `TX_IDLE`) turns them into set events. The tracker goes to `TX_BUSY` whenever the holding register is full. It goes to `TX_RELOAD` when the holding register is empty and the shift register is busy. It goes to `TX_IDLE` when both are empty. Leaving `TX_BUSY` raises the holding-empty event. Entering `TX_IDLE` from either other state raises the transmitter-done event. The three asynchronous lines (external status, peripheral status, clear-to-send) each pass through a synchronizer of `SYNC_STAGES` flops. A parameter then selects whether that line gives a level, a rising edge or a falling edge. A control write loads the interrupt-enable and transmit-request bits.

Top module: `uart_stat_irq`

## Requirements
- R1: The status byte is, from bit 7 down to bit 0: transmit holding empty, transmit shift empty, peripheral-status flag, external status, framing error, parity error, overrun error, data available. Bits 7 and 6 follow `tx_hold_empty` and `tx_shift_empty` directly.
- R2: `irq_n` is low exactly when the interrupt-enable bit is 1 and at least one enabled cause is pending. With the enable bit at 0, a pending cause leaves `irq_n` high.
- R3: `rx_load` sets data available (bit 0) on the next edge, and it also raises a cause. Only `rd_data` clears the bit. When `rx_load` and `rd_data` fall in the same cycle, the bit stays set.
- R4: On each `rx_load`, the block loads overrun (bit 1) with 1 if data available was still set and not being read in that cycle, and with 0 otherwise. Parity error (bit 2) and framing error (bit 3) take `rx_par_err` and `rx_frm_err`. Between loads, other accesses leave bits 1 to 3 unchanged.
- R5: When the holding register goes from full to empty, a holding-empty cause is latched. That cause drives the interrupt only while the transmit-request bit is 1. `rd_stat` or `wr_char` clears it.
- R6: When both transmitter registers become empty from a non-idle state, a transmitter-done cause is latched. `rd_stat` or `wr_char` clears it.
- R7: A high-to-low transition on `periph_n` sets bit 5 and raises a cause. `rd_stat` clears both. A low-to-high transition has no effect.
- R8: A low-to-high transition on `cts` while the transmitter is idle latches a cause, and `rd_stat` clears it. The same transition while the holding register is full raises nothing.
- R9: Bit 4 is 1 while `ext_stat_n` is low. It is a level and raises no interrupt.
- R10: `rst` clears every pending cause, bits 0 to 5 and both control bits. After reset, a new cause leaves `irq_n` high until a control write sets the enable bit.
- R11: `ctl_wr` loads `ctl_ie` and `ctl_tr` into the enable and transmit-request bits, and they take effect on the next edge.
- R12: A change on `ext_stat_n`, `periph_n` or `cts` becomes visible within `SYNC_STAGES`+1 clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Master reset, active high, synchronous |
| rx_load | input | 1 | Pulse: a character entered the receive holding register |
| rx_par_err | input | 1 | Parity check result of the loaded character |
| rx_frm_err | input | 1 | Missing stop bit on the loaded character |
| tx_hold_empty | input | 1 | Transmit holding register empty (level) |
| tx_shift_empty | input | 1 | Transmit shift register empty (level) |
| ext_stat_n | input | 1 | External status line, active low, asynchronous |
| periph_n | input | 1 | Peripheral status line, falling edge flags, asynchronous |
| cts | input | 1 | Clear-to-send line, rising edge counts, asynchronous |
| rd_data | input | 1 | Pulse: CPU read of received data |
| rd_stat | input | 1 | Pulse: CPU read of the status byte |
| wr_char | input | 1 | Pulse: CPU write of a character to transmit |
| ctl_wr | input | 1 | Pulse: load the control bits |
| ctl_ie | input | 1 | Interrupt-enable value for a control write |
| ctl_tr | input | 1 | Transmit-request value for a control write |
| stat | output | 8 | Status byte |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The bench builds the block with the default `SYNC_STAGES` of 2. With that value, an edge on an asynchronous line reaches the status byte or the interrupt three edges later. A four-cycle wait therefore settles every such case. The same build lets the bench cover more than the simple sets and clears. It covers a load and a data read in the same cycle, the holding-empty cause while the transmit-request bit is 0, clear-to-send while the transmitter is busy, and both transmitter events coming from one return to idle.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;

    localparam int STAT_W = 8;

    // status byte bit positions
    localparam int ST_DA   = 0;
    localparam int ST_OE   = 1;
    localparam int ST_PE   = 2;
    localparam int ST_FE   = 3;
    localparam int ST_ES   = 4;
    localparam int ST_PSI  = 5;
    localparam int ST_TSRE = 6;
    localparam int ST_THRE = 7;

    // asynchronous inputs, and what each one yields
    localparam int NUM_ASYNC = 3;
    localparam int AIN_EXT   = 0;
    localparam int AIN_PER   = 1;
    localparam int AIN_CTS   = 2;

    localparam logic [1:0] SM_LEVEL = 2'd0;
    localparam logic [1:0] SM_RISE  = 2'd1;
    localparam logic [1:0] SM_FALL  = 2'd2;

    // interrupt causes
    localparam int NUM_CAUSE = 5;
    localparam int C_DA   = 0;
    localparam int C_PSI  = 1;
    localparam int C_THRE = 2;
    localparam int C_DONE = 3;
    localparam int C_CTS  = 4;

    typedef enum logic [1:0] {
        TX_IDLE   = 2'd0,
        TX_RELOAD = 2'd1,
        TX_BUSY   = 2'd2
    } tx_state_t;

endpackage

// File: rtl/usi_sync.sv
module usi_sync #(
    parameter int         STAGES  = 2,
    parameter logic [1:0] MODE    = 2'd0,
    parameter logic       RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic sig
);
    import uart_stat_pkg::*;

    logic [STAGES-1:0] chain;
    logic              lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign lvl = chain[STAGES-1];

    generate
        if (MODE == SM_LEVEL) begin : g_level
            assign sig = lvl;
        end else begin : g_edge
            logic prev;
            always_ff @(posedge clk) begin
                if (rst) prev <= RST_VAL;
                else     prev <= lvl;
            end
            if (MODE == SM_RISE) begin : g_rise
                assign sig = lvl & ~prev;
            end else begin : g_fall
                assign sig = ~lvl & prev;
            end

            // an edge event lasts exactly one cycle (R7, R8)
            p_evt_pulse_r7: assert property (@(posedge clk) disable iff (rst)
                sig |=> !sig);
        end
    endgenerate

endmodule

// File: rtl/usi_txtrack.sv
module usi_txtrack (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     hold_empty,
    input  logic                     shift_empty,
    output uart_stat_pkg::tx_state_t state,
    output logic                     thre_evt,
    output logic                     done_evt
);
    import uart_stat_pkg::*;

    tx_state_t nxt;

    always_comb begin
        if (!hold_empty)       nxt = TX_BUSY;
        else if (!shift_empty) nxt = TX_RELOAD;
        else                   nxt = TX_IDLE;
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= TX_IDLE;
        else     state <= nxt;
    end

    // outputs
    always_comb begin
        thre_evt = 1'b0;
        done_evt = 1'b0;
        unique case (state)
            TX_BUSY: begin
                thre_evt = hold_empty;
                done_evt = hold_empty & shift_empty;
            end
            TX_RELOAD: begin
                done_evt = hold_empty & shift_empty;
            end
            TX_IDLE: begin
                thre_evt = 1'b0;
            end
            default: begin
                thre_evt = 1'b0;
            end
        endcase
    end

    p_idle_entry_r6: assert property (@(posedge clk) disable iff (rst)
        done_evt |=> (state == TX_IDLE));
    p_reload_exit_r5: assert property (@(posedge clk) disable iff (rst)
        thre_evt |=> (state != TX_BUSY));

endmodule

// File: rtl/usi_cause.sv
module usi_cause (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);
    // a set in the same cycle as a clear wins
    always_ff @(posedge clk) begin
        if (rst)      q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end

    p_set_wins_r3: assert property (@(posedge clk) disable iff (rst)
        set |=> q);
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (q && !clr) |=> q);

endmodule

// File: rtl/uart_stat_irq.sv
module uart_stat_irq #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_load,
    input  logic       rx_par_err,
    input  logic       rx_frm_err,
    input  logic       tx_hold_empty,
    input  logic       tx_shift_empty,
    input  logic       ext_stat_n,
    input  logic       periph_n,
    input  logic       cts,
    input  logic       rd_data,
    input  logic       rd_stat,
    input  logic       wr_char,
    input  logic       ctl_wr,
    input  logic       ctl_ie,
    input  logic       ctl_tr,
    output logic [7:0] stat,
    output logic       irq_n
);
    import uart_stat_pkg::*;

    localparam logic [2*NUM_ASYNC-1:0] AMODE = {SM_RISE, SM_FALL, SM_LEVEL};

    logic [NUM_ASYNC-1:0] a_in, a_sig;
    logic [NUM_CAUSE-1:0] c_set, c_clr, c_q, c_en;
    logic                 ie_q, tr_q;
    logic                 oe_q, pe_q, fe_q;
    tx_state_t            tx_state;
    logic                 thre_evt, done_evt;

    assign a_in[AIN_EXT] = ext_stat_n;
    assign a_in[AIN_PER] = periph_n;
    assign a_in[AIN_CTS] = cts;

    generate
        for (genvar g = 0; g < NUM_ASYNC; g++) begin : g_sync
            usi_sync #(
                .STAGES (SYNC_STAGES),
                .MODE   (AMODE[2*g +: 2]),
                .RST_VAL(1'b1)
            ) u_sync (
                .clk(clk),
                .rst(rst),
                .din(a_in[g]),
                .sig(a_sig[g])
            );
        end
    endgenerate

    usi_txtrack u_tx (
        .clk        (clk),
        .rst        (rst),
        .hold_empty (tx_hold_empty),
        .shift_empty(tx_shift_empty),
        .state      (tx_state),
        .thre_evt   (thre_evt),
        .done_evt   (done_evt)
    );

    // set events and clearing accesses per cause
    always_comb begin
        c_set[C_DA]   = rx_load;
        c_clr[C_DA]   = rd_data;
        c_set[C_PSI]  = a_sig[AIN_PER];
        c_clr[C_PSI]  = rd_stat;
        c_set[C_THRE] = thre_evt;
        c_clr[C_THRE] = rd_stat | wr_char;
        c_set[C_DONE] = done_evt;
        c_clr[C_DONE] = rd_stat | wr_char;
        c_set[C_CTS]  = a_sig[AIN_CTS] & (tx_state == TX_IDLE);
        c_clr[C_CTS]  = rd_stat;
    end

    generate
        for (genvar c = 0; c < NUM_CAUSE; c++) begin : g_cause
            usi_cause u_cause (
                .clk(clk),
                .rst(rst),
                .set(c_set[c]),
                .clr(c_clr[c]),
                .q  (c_q[c])
            );
        end
    endgenerate

    // control bits
    always_ff @(posedge clk) begin
        if (rst) begin
            ie_q <= 1'b0;
            tr_q <= 1'b0;
        end else if (ctl_wr) begin
            ie_q <= ctl_ie;
            tr_q <= ctl_tr;
        end
    end

    // receive error flags, refreshed per loaded character
    always_ff @(posedge clk) begin
        if (rst) begin
            oe_q <= 1'b0;
            pe_q <= 1'b0;
            fe_q <= 1'b0;
        end else if (rx_load) begin
            oe_q <= c_q[C_DA] & ~rd_data;
            pe_q <= rx_par_err;
            fe_q <= rx_frm_err;
        end
    end

    always_comb begin
        stat          = '0;
        stat[ST_DA]   = c_q[C_DA];
        stat[ST_OE]   = oe_q;
        stat[ST_PE]   = pe_q;
        stat[ST_FE]   = fe_q;
        stat[ST_ES]   = ~a_sig[AIN_EXT];
        stat[ST_PSI]  = c_q[C_PSI];
        stat[ST_TSRE] = tx_shift_empty;
        stat[ST_THRE] = tx_hold_empty;
    end

    always_comb begin
        c_en         = c_q;
        c_en[C_THRE] = c_q[C_THRE] & tr_q;
        irq_n        = ~(ie_q & (|c_en));
    end

    p_da_set_r3: assert property (@(posedge clk) disable iff (rst)
        rx_load |=> stat[ST_DA]);
    p_da_keep_r3: assert property (@(posedge clk) disable iff (rst)
        (stat[ST_DA] && !rd_data) |=> stat[ST_DA]);
    p_oe_set_r4: assert property (@(posedge clk) disable iff (rst)
        (rx_load && stat[ST_DA] && !rd_data) |=> stat[ST_OE]);
    p_err_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !rx_load |=> $stable(stat[3:1]));
    p_psi_clr_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_stat && !a_sig[AIN_PER]) |=> !stat[ST_PSI]);

endmodule

// File: tb/tb_uart_stat_irq.sv
module tb_uart_stat_irq;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst;
    logic rx_load, rx_par_err, rx_frm_err;
    logic tx_hold_empty, tx_shift_empty;
    logic ext_stat_n, periph_n, cts;
    logic rd_data, rd_stat, wr_char;
    logic ctl_wr, ctl_ie, ctl_tr;
    logic [7:0] stat;
    logic irq_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_stat_irq #(.SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst),
        .rx_load(rx_load), .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err),
        .tx_hold_empty(tx_hold_empty), .tx_shift_empty(tx_shift_empty),
        .ext_stat_n(ext_stat_n), .periph_n(periph_n), .cts(cts),
        .rd_data(rd_data), .rd_stat(rd_stat), .wr_char(wr_char),
        .ctl_wr(ctl_wr), .ctl_ie(ctl_ie), .ctl_tr(ctl_tr),
        .stat(stat), .irq_n(irq_n)
    );

    // [10]load [9]par [8]frm [7]rd_data [6]rd_stat [5]wr_char [4:1]stat[3:0] [0]irq_n
    localparam logic [10:0] VEC [10] = '{
        11'b110_000_0101_0,
        11'b000_100_0100_1,
        11'b101_000_1001_0,
        11'b100_000_0011_0,
        11'b000_010_0011_0,
        11'b000_100_0010_1,
        11'b100_100_0001_0,
        11'b100_100_0001_0,
        11'b000_001_0001_0,
        11'b000_100_0000_1
    };

    task automatic chk8(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s stat actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk1(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe_clear();
        rx_load = 0; rd_data = 0; rd_stat = 0; wr_char = 0; ctl_wr = 0;
    endtask

    task automatic ctl(logic ie, logic tr);
        ctl_wr = 1; ctl_ie = ie; ctl_tr = tr;
        step();
        ctl_wr = 0;
    endtask

    task automatic pulse_rd_stat();
        rd_stat = 1; step(); rd_stat = 0;
    endtask

    task automatic pulse_wr_char();
        wr_char = 1; step(); wr_char = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1; strobe_clear();
        rx_par_err = 0; rx_frm_err = 0; ctl_ie = 0; ctl_tr = 0;
        tx_hold_empty = 1; tx_shift_empty = 1;
        ext_stat_n = 1; periph_n = 1; cts = 0;
        step(3);
        rst = 0;
        step();
        chk8("R10 reset status", stat, 8'hC0);
        chk1("R10 reset irq_n", irq_n, 1'b1);

        // R2: cause with enable off
        rx_load = 1; step(); rx_load = 0;
        chk8("R2 data flagged", stat, 8'hC1);
        chk1("R2 no irq while disabled", irq_n, 1'b1);
        ctl(1'b1, 1'b1);
        chk1("R11 enable takes effect", irq_n, 1'b0);
        rd_data = 1; step(); rd_data = 0;
        chk1("R3 data read clears", irq_n, 1'b1);

        // R3/R4 receive path vectors
        for (int i = 0; i < 10; i++) begin
            rx_load    = VEC[i][10];
            rx_par_err = VEC[i][9];
            rx_frm_err = VEC[i][8];
            rd_data    = VEC[i][7];
            rd_stat    = VEC[i][6];
            wr_char    = VEC[i][5];
            step();
            strobe_clear();
            chk8($sformatf("R4 vector %0d", i), stat, {4'b1100, VEC[i][4:1]});
            chk1($sformatf("R3 vector %0d irq", i), irq_n, VEC[i][0]);
        end
        rx_par_err = 0; rx_frm_err = 0;

        // R5: holding-empty gated by transmit-request
        ctl(1'b1, 1'b0);
        tx_hold_empty = 0; tx_shift_empty = 0; step();
        tx_hold_empty = 1; step();
        chk8("R1 transmit bits", stat, 8'h80);
        chk1("R5 masked by tr=0", irq_n, 1'b1);
        ctl(1'b1, 1'b1);
        chk1("R5 tr enables", irq_n, 1'b0);
        pulse_wr_char();
        chk1("R5 char write clears", irq_n, 1'b1);

        // R6: done, cleared by char write
        tx_shift_empty = 1; step();
        chk1("R6 done raises", irq_n, 1'b0);
        pulse_wr_char();
        chk1("R6 char write clears", irq_n, 1'b1);

        // R5/R6 cleared by status read
        tx_hold_empty = 0; tx_shift_empty = 0; step();
        tx_hold_empty = 1; step();
        chk1("R5 raise again", irq_n, 1'b0);
        pulse_rd_stat();
        chk1("R5 status read clears", irq_n, 1'b1);
        tx_shift_empty = 1; step();
        chk1("R6 raise again", irq_n, 1'b0);
        pulse_rd_stat();
        chk1("R6 status read clears", irq_n, 1'b1);

        // R7 peripheral status edge
        periph_n = 0; step(4);
        chk1("R7 falling edge sets bit5", stat[5], 1'b1);
        chk1("R7 falling edge irq", irq_n, 1'b0);
        pulse_rd_stat();
        chk1("R7 status read clears bit5", stat[5], 1'b0);
        chk1("R7 status read clears irq", irq_n, 1'b1);
        periph_n = 1; step(4);
        chk1("R7 rising edge ignored bit5", stat[5], 1'b0);
        chk1("R7 rising edge ignored irq", irq_n, 1'b1);

        // R9/R12 external status level
        ext_stat_n = 0; step(3);
        chk1("R12 ext visible in 3 edges", stat[4], 1'b1);
        chk1("R9 ext no irq", irq_n, 1'b1);
        ext_stat_n = 1; step(4);
        chk1("R9 ext released", stat[4], 1'b0);

        // R8 clear-to-send
        cts = 1; step(4);
        chk1("R8 cts edge while idle", irq_n, 1'b0);
        pulse_rd_stat();
        chk1("R8 status read clears", irq_n, 1'b1);
        cts = 0; step(4);
        tx_hold_empty = 0; step();
        cts = 1; step(4);
        chk1("R8 cts ignored when busy", irq_n, 1'b1);
        cts = 0;
        tx_hold_empty = 1; step();
        chk1("R6 return to idle raises", irq_n, 1'b0);
        pulse_rd_stat();
        chk1("R5 both cleared by status read", irq_n, 1'b1);

        // R10 reset clears causes and enables
        rx_load = 1; step(); rx_load = 0;
        chk1("R3 pending before reset", irq_n, 1'b0);
        rst = 1; step(2); rst = 0; step();
        chk8("R10 status after reset", stat, 8'hC0);
        chk1("R10 irq after reset", irq_n, 1'b1);
        rx_load = 1; step(); rx_load = 0;
        chk1("R10 enable cleared", irq_n, 1'b1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule